// File: doc/BRIEF.md
# Shift unit with status flags

This block is the shift stage of an integer execution pipeline. Each accepted request carries a 64-bit operand, an 8-bit count, a size code (8, 16, 32 or 64 bits), a shift-kind code and the current flag word. The block returns the shifted value in the chosen width. It also returns a new flag word with carry, parity, auxiliary carry, zero, sign and overflow, and a strobe that says whether the flags should be written back.

Both sides use a valid/ready handshake with one register stage. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its answer is presented from the next cycle on, and is held unchanged while `out_ready` is low. `in_ready` is high whenever the output slot is empty or is being emptied in the same cycle. A full slot with `out_ready` low therefore back-pressures the input at once, and no request is dropped or duplicated.

Top module: `shift_flag_unit`

## Requirements
- R1: The count is reduced to its low 6 bits when the size code is 3 (64-bit), and to its low 5 bits for size codes 0, 1 and 2 (8, 16, 32 bits). Every other rule uses this reduced count.
- R2: When the reduced count is zero, the result is the operand cut to the selected width, the returned flags equal `in_flags`, and `out_flags_we` is 0.
- R3: Shift-kind code 4 shifts left with zero fill. Carry is the last bit that leaves the top of the selected width.
- R4: Code 5 shifts right with zero fill and code 7 shifts right with sign fill. For both, carry is the last bit that leaves the bottom.
- R5: For codes 4 and 5 with a reduced count at or above the width, the result is zero and carry is 0. For code 7 in that case, every result bit and carry equal the operand's sign bit.
- R6: For a reduced count of exactly 1, overflow is set as follows: code 4 gives result MSB XOR new carry, code 5 gives the original operand MSB, and code 7 gives 0. For any other non-zero count, overflow is 0.
- R7: Zero is set when the sized result is all zeros. Sign is the MSB of the sized result.
- R8: For a non-zero count, parity is 1 when result bits 7:0 hold an even number of ones, auxiliary carry is 0, and `out_flags_we` is 1.
- R9: Shift-kind codes other than 4, 5 and 7 behave like a zero count, as in R2.
- R10: Result bits above the selected width are always 0.
- R11: `in_ready` equals `!out_valid || out_ready`. A request taken on an edge is presented in the very next cycle. While `out_valid` is high and `out_ready` is low, all outputs are held.
- R12: During and right after reset, `out_valid` is 0.

Flag word layout (in and out): bit 0 carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign, bit 5 overflow. Size codes: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_operand | input | 64 | Value to shift |
| in_count | input | 8 | Raw shift count |
| in_size | input | 2 | Operand size code |
| in_kind | input | 3 | Shift kind code (4, 5, 7) |
| in_flags | input | 6 | Current flag word |
| out_valid | output | 1 | Answer present |
| out_ready | input | 1 | Consumer takes the answer |
| out_result | output | 64 | Shifted value, zero above width |
| out_flags | output | 6 | New flag word |
| out_flags_we | output | 1 | Flag word should be written |

## Verification
Some rules are checked by the embedded properties on every cycle:
- the handshake rules, namely ready derivation, one-cycle presentation and holding under stall;
- clearing of bits above the width;
- flag pass-through and deasserted write strobe on a zero reduced count;
- auxiliary carry cleared, overflow clear for multi-bit counts, and sign matching the result MSB on any real shift.

The exact bit patterns need the bench's scenarios, which compare against a one-bit-per-step model. These patterns are carry at the width boundaries, parity, count reduction for large raw counts, and sign fill for arithmetic shifts beyond the width.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int DATA_W = 64;
  localparam int CNT_W  = 8;
  localparam int SH_W   = $clog2(DATA_W);      // reduced count width
  localparam int WID_W  = SH_W + 1;            // holds the value DATA_W
  localparam int SZ_W   = 2;
  localparam int KIND_W = 3;
  localparam int NSIZES = 4;

  localparam logic [KIND_W-1:0] KIND_SHL = 3'd4;
  localparam logic [KIND_W-1:0] KIND_SHR = 3'd5;
  localparam logic [KIND_W-1:0] KIND_SAR = 3'd7;

  localparam logic [SZ_W-1:0] SIZE_64 = 2'd3;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);

  function automatic logic [WID_W-1:0] size_bits(input logic [SZ_W-1:0] sz);
    return WID_W'(8) << sz;
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input logic [SZ_W-1:0] sz);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(size_bits(sz))) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/shf_count_mask.sv
module shf_count_mask
  import shf_pkg::*;
(
  input  logic [SZ_W-1:0]  sz,
  input  logic [CNT_W-1:0] count,
  output logic [SH_W-1:0]  cnt_m,
  output logic [WID_W-1:0] width,
  output logic             cnt_zero,
  output logic             cnt_one,
  output logic             cnt_ge_w
);
  localparam int NARROW_W = SH_W - 1;

  logic unused_cnt_hi;
  logic [SH_W-1:0] lane_mask;

  // reduce count: full SH_W bits only for the widest size
  generate
    for (genvar b = 0; b < SH_W; b++) begin : g_lane
      if (b < NARROW_W) begin : g_low
        assign lane_mask[b] = 1'b1;
      end else begin : g_top
        assign lane_mask[b] = (sz == SIZE_64);
      end
    end
  endgenerate

  assign unused_cnt_hi = ^count[CNT_W-1:SH_W];
  assign cnt_m    = count[SH_W-1:0] & lane_mask;
  assign width    = size_bits(sz);
  assign cnt_zero = (cnt_m == '0);
  assign cnt_one  = (cnt_m == SH_W'(1));
  assign cnt_ge_w = ({1'b0, cnt_m} >= width);
endmodule

// File: rtl/shf_datapath.sv
module shf_datapath
  import shf_pkg::*;
(
  input  logic [DATA_W-1:0] opnd,
  input  logic [SZ_W-1:0]   sz,
  input  logic [KIND_W-1:0] kind,
  input  logic [SH_W-1:0]   cnt_m,
  input  logic [WID_W-1:0]  width,
  input  logic              cnt_ge_w,
  output logic [DATA_W-1:0] res,
  output logic              cry,
  output logic              ovf1,
  output logic              kind_ok
);
  logic [DATA_W-1:0] msk, x, sx, l_val, r_val, a_val;
  logic [SH_W-1:0]   top_idx, low_idx, l_idx;
  logic [WID_W-1:0]  l_dist;
  logic              sbit;

  assign msk     = size_mask(sz);
  assign x       = opnd & msk;
  assign top_idx = SH_W'(width - WID_W'(1));
  assign sbit    = x[top_idx];
  assign sx      = sbit ? (x | ~msk) : x;

  assign l_val   = (x << cnt_m) & msk;
  assign r_val   = x >> cnt_m;
  assign a_val   = DATA_W'($signed(sx) >>> cnt_m) & msk;

  assign l_dist  = width - {1'b0, cnt_m};
  assign l_idx   = l_dist[SH_W-1:0];
  assign low_idx = cnt_m - SH_W'(1);

  always_comb begin
    kind_ok = 1'b1;
    res     = x;
    cry     = 1'b0;
    ovf1    = 1'b0;
    case (kind)
      KIND_SHL: begin
        res  = l_val;
        cry  = cnt_ge_w ? 1'b0 : x[l_idx];
        ovf1 = l_val[top_idx] ^ (cnt_ge_w ? 1'b0 : x[l_idx]);
      end
      KIND_SHR: begin
        res  = r_val;
        cry  = cnt_ge_w ? 1'b0 : x[low_idx];
        ovf1 = sbit;
      end
      KIND_SAR: begin
        res  = a_val;
        cry  = sx[low_idx];
        ovf1 = 1'b0;
      end
      default: kind_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/shf_flag_gen.sv
module shf_flag_gen
  import shf_pkg::*;
(
  input  logic [DATA_W-1:0] res,
  input  logic [WID_W-1:0]  width,
  input  logic              cry,
  input  logic              ovf1,
  input  logic              kind_ok,
  input  logic              cnt_zero,
  input  logic              cnt_one,
  input  flags_t            flags_in,
  output flags_t            flags_out,
  output logic              flags_we
);
  logic [SH_W-1:0] top_idx;
  flags_t          fresh;

  assign top_idx = SH_W'(width - WID_W'(1));

  always_comb begin
    fresh.cry = cry;
    fresh.par = ~^res[7:0];
    fresh.aux = 1'b0;
    fresh.zro = (res == '0);
    fresh.sgn = res[top_idx];
    fresh.ovf = cnt_one ? ovf1 : 1'b0;
  end

  assign flags_we  = kind_ok && !cnt_zero;
  assign flags_out = flags_we ? fresh : flags_in;
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       in_operand,
  input  logic [7:0]        in_count,
  input  logic [1:0]        in_size,
  input  logic [2:0]        in_kind,
  input  logic [5:0]        in_flags,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [63:0]       out_result,
  output logic [5:0]        out_flags,
  output logic              out_flags_we
);
  logic [SH_W-1:0]   cnt_m;
  logic [WID_W-1:0]  width;
  logic              cnt_zero, cnt_one, cnt_ge_w;
  logic [DATA_W-1:0] res;
  logic              cry, ovf1, kind_ok, we;
  flags_t            fl_in, fl_new;
  logic              take;

  assign fl_in = flags_t'(in_flags);

  shf_count_mask u_cnt (
    .sz(in_size), .count(in_count), .cnt_m(cnt_m), .width(width),
    .cnt_zero(cnt_zero), .cnt_one(cnt_one), .cnt_ge_w(cnt_ge_w)
  );

  shf_datapath u_dp (
    .opnd(in_operand), .sz(in_size), .kind(in_kind), .cnt_m(cnt_m),
    .width(width), .cnt_ge_w(cnt_ge_w), .res(res), .cry(cry),
    .ovf1(ovf1), .kind_ok(kind_ok)
  );

  shf_flag_gen u_flg (
    .res(res), .width(width), .cry(cry), .ovf1(ovf1), .kind_ok(kind_ok),
    .cnt_zero(cnt_zero), .cnt_one(cnt_one), .flags_in(fl_in),
    .flags_out(fl_new), .flags_we(we)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_flags    <= '0;
      out_flags_we <= 1'b0;
    end else if (take) begin
      out_valid    <= 1'b1;
      out_result   <= res;
      out_flags    <= fl_new;
      out_flags_we <= we;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  AST_TAKE_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid) else $error("take not presented"); // R11

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
      && $stable(out_flags) && $stable(out_flags_we))) else $error("stall"); // R11

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((out_result & ~size_mask($past(in_size))) == '0)) else $error("upper"); // R10

  AST_ZERO_COUNT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ((in_size == SIZE_64) ? (in_count[5:0] == 6'd0) : (in_count[4:0] == 5'd0)))
      |=> (!out_flags_we && out_flags == $past(in_flags))) else $error("zero count"); // R2

  AST_AUX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags_we) |-> !out_flags[2]) else $error("aux"); // R8

  AST_MULTI_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_kind == KIND_SHL) && in_count[4:1] != 4'd0) |=> !out_flags[5]) else $error("ovf"); // R6

  AST_SIGN_IS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (take && we) |=> (out_flags[4] == out_result[$past(size_bits(in_size)) - WID_W'(1)]))
    else $error("sign"); // R7
endmodule

// File: tb/test_shift_flag_unit.sv
`timescale 1ns/1ps
module test_shift_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_operand = '0;
  logic [7:0]  in_count = '0;
  logic [1:0]  in_size = '0;
  logic [2:0]  in_kind = '0;
  logic [5:0]  in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic [5:0]  out_flags;
  logic        out_flags_we;

  always #2.5 clk = ~clk;

  shift_flag_unit i_shift_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_count(in_count), .in_size(in_size),
    .in_kind(in_kind), .in_flags(in_flags), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_flags(out_flags),
    .out_flags_we(out_flags_we)
  );

  typedef struct {
    logic [63:0] res;
    logic [63:0] msk;
    logic [5:0]  fl;
    logic        we;
    int          w;
    int          cm;
    int          raw;
    logic [2:0]  kind;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic took = 1'b0;
  logic prev_took = 1'b0;
  logic prev_stall = 1'b0;
  logic [63:0] prev_res;
  logic [5:0]  prev_fl;

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic exp_t model(input logic [63:0] a, input logic [7:0] c,
                                 input logic [1:0] sz, input logic [2:0] k,
                                 input logic [5:0] fi);
    exp_t e;
    logic [63:0] x;
    logic cf, sb, of;
    e.w   = 8 << sz;
    e.cm  = (sz == 2'd3) ? int'(c[5:0]) : int'(c[4:0]);
    e.raw = int'(c);
    e.kind = k;
    e.msk = (e.w == 64) ? '1 : ((64'd1 << e.w) - 64'd1);
    x = a & e.msk;
    e.res = x; e.fl = fi; e.we = 1'b0;
    if (e.cm == 0 || !(k == 3'd4 || k == 3'd5 || k == 3'd7)) return e;
    sb = x[e.w-1];
    cf = 1'b0;
    for (int i = 0; i < e.cm; i++) begin
      if (k == 3'd4) begin
        cf = x[e.w-1];
        x = (x << 1) & e.msk;
      end else begin
        cf = x[0];
        x = x >> 1;
        if (k == 3'd7 && sb) x[e.w-1] = 1'b1;
      end
    end
    if (k != 3'd7 && e.cm >= e.w) cf = 1'b0;
    of = 1'b0;
    if (e.cm == 1) of = (k == 3'd4) ? (x[e.w-1] ^ cf) : (k == 3'd5) ? sb : 1'b0;
    e.res = x;
    e.fl = {of, x[e.w-1], (x == 64'd0), 1'b0, ~^x[7:0], cf};
    e.we = 1'b1;
    return e;
  endfunction

  function automatic string main_tag(input exp_t e);
    if (!(e.kind == 3'd4 || e.kind == 3'd5 || e.kind == 3'd7)) return "R9";
    if (e.cm == 0) return "R2";
    if (e.raw != e.cm) return "R1";
    if (e.cm >= e.w) return "R5";
    return (e.kind == 3'd4) ? "R3" : "R4";
  endfunction

  // monitor: samples 0.5 ns before each rising edge
  always @(negedge clk) begin
    #2;
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst_n) begin
      took = in_valid && in_ready;
      check(in_ready == (!out_valid || out_ready), "R11 ready", in_ready, !out_valid || out_ready);
      if (prev_took) check(out_valid, "R11 latency", out_valid, 1);
      if (prev_stall) check(out_valid && out_result == prev_res && out_flags == prev_fl,
                            "R11 hold", out_result, prev_res);
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R11 spurious", 1, 0);
        end else begin
          exp_t e;
          string t;
          e = q.pop_front();
          t = main_tag(e);
          check(out_result == e.res, {t, " result"}, out_result, e.res);
          check((out_result & ~e.msk) == 64'd0, "R10 upper", out_result, 0);
          check(out_flags[0] == e.fl[0], {t, " carry"}, out_flags, e.fl);
          check(out_flags[5] == e.fl[5], "R6 overflow", out_flags, e.fl);
          check(out_flags[4:3] == e.fl[4:3], "R7 sign/zero", out_flags, e.fl);
          check(out_flags[2:1] == e.fl[2:1] && out_flags_we == e.we,
                (e.we ? "R8 parity/aux/we" : {t, " keep/we"}),
                {out_flags_we, out_flags}, {e.we, e.fl});
        end
      end
      if (took) q.push_back(model(in_operand, in_count, in_size, in_kind, in_flags));
      prev_took  = took;
      prev_stall = out_valid && !out_ready;
      prev_res   = out_result;
      prev_fl    = out_flags;
    end else begin
      took = 1'b0;
      prev_took = 1'b0;
      prev_stall = 1'b0;
    end
  end

  logic bp_on = 1'b0;
  always @(negedge clk) out_ready = bp_on ? (($urandom % 4) != 0) : 1'b1;

  task automatic send(input logic [63:0] a, input logic [7:0] c, input logic [1:0] sz,
                      input logic [2:0] k, input logic [5:0] fi);
    @(negedge clk);
    in_operand = a; in_count = c; in_size = sz; in_kind = k; in_flags = fi;
    in_valid = 1'b1;
    do @(posedge clk); while (!took);
  endtask

  initial begin
    logic [63:0] pats [4];
    pats[0] = 64'h8000_0000_8000_8080;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h0123_4567_89AB_CDEF;
    pats[3] = 64'h7F5A_3C01_4E81_0F71;
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R12 reset valid", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(out_valid == 1'b0 && in_ready, "R12 after reset", {in_ready, out_valid}, 2'b10);

    // directed boundaries for every size and kind
    for (int sz = 0; sz < 4; sz++) begin
      for (int ki = 0; ki < 3; ki++) begin
        for (int ci = 0; ci < 9; ci++) begin
          for (int p = 0; p < 4; p++) begin
            int w;
            logic [2:0] k;
            logic [7:0] c;
            w = 8 << sz;
            k = (ki == 0) ? 3'd4 : (ki == 1) ? 3'd5 : 3'd7;
            case (ci)
              0: c = 8'd0;
              1: c = 8'd1;
              2: c = 8'(w - 1);
              3: c = 8'(w);
              4: c = 8'd31;
              5: c = 8'd63;
              6: c = 8'd2;
              7: c = 8'd33;
              default: c = 8'd193;
            endcase
            send(pats[p], c, 2'(sz), k, 6'(p * 13 + ci));
          end
        end
      end
    end
    // unlisted kind codes
    send(64'hDEAD_BEEF_0000_0001, 8'd3, 2'd2, 3'd6, 6'h2A);
    send(64'hDEAD_BEEF_0000_0001, 8'd1, 2'd3, 3'd0, 6'h15);
    // random traffic with back-pressure
    bp_on = 1'b1;
    for (int n = 0; n < 600; n++) begin
      logic [2:0] k;
      case ($urandom % 5)
        0: k = 3'd4;
        1: k = 3'd5;
        2: k = 3'd7;
        3: k = 3'd4;
        default: k = 3'($urandom);
      endcase
      send({$urandom, $urandom}, 8'($urandom), 2'($urandom), k, 6'($urandom));
      if ((n % 7) == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    bp_on = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule